// File: doc/BRIEF.md
# Mesh Configuration Word Router

This block is the routing cell that carries configuration words through a two-dimensional array of identical cells. No cell knows its own position. Each word instead carries the remaining distance to its target in rows (y) and columns (x). A cell that holds a word removes one step from one of the two distances and hands the word to its neighbour in that direction. When both distances have reached zero, the word has arrived, and its data goes into the cell's local configuration memory at the address the word names.

Each cell has two independent input slots, one fed by the neighbour above it (the y input) and one fed by the neighbour to its left (the x input). A slot that holds a word raises a registered busy line towards the neighbour that feeds it. A word that still has both distances to travel takes the y hop when the y neighbour is free and the x hop otherwise, so traffic spreads around congestion. The cell's own computation may start only when the router is idle. An array is built by abutting cells. Words can be injected in any order, and the configured contents do not depend on that order.

Top module: `cfg_mesh_cell`

## Requirements
- R1: A word is `{flag, dy, dx, addr, data}`, MSB first. With the defaults, flag is bit 17, dy is bits 16:14, dx is bits 13:11, addr is bits 10:8 and data is bits 7:0. Only words with flag=1 are taken into a slot. A word with flag=0 leaves the busy line low and causes no memory write.
- R2: A held word with dy>0 and dx>0 goes out on the y output with dy reduced by one when busy_y_dn is low.
- R3: A held word with dy>0 and dx>0 goes out on the x output with dx reduced by one when busy_y_dn is high and busy_x_dn is low.
- R4: A held word with dy>0 and dx>0 stays in its slot, with the slot's busy line high and neither output valid, while both downstream busy lines are high.
- R5: A held word with dy>0 and dx=0 only ever takes the y output, with dy reduced by one. It waits while busy_y_dn is high, even when the x neighbour is free.
- R6: A held word with dy=0 and dx>0 only ever takes the x output, with dx reduced by one.
- R7: A held word with dy=0 and dx=0 is written into local memory. cfg_we pulses for one cycle, on the cycle after the word is held, carrying its addr and data. rd_data shows memory[rd_addr] one cycle after rd_addr is presented.
- R8: op_go is high in a cycle only if, in the previous cycle, op_req was high, both slots were empty and no flagged word was arriving.
- R9: When a word has been held by two busy neighbours and both become free in the same cycle, it takes the y output.
- R10: busy_y_o and busy_x_o are registered and equal to the fill state of the y and x slots. Both are low after reset. No word is ever offered to a neighbour whose busy input is high.
- R11: In an array of cells, a set of words to distinct targets leaves the same final memory contents whatever order the words are injected in.
- R12: When both slots want the same output in the same cycle, the y-slot word goes first and the x-slot word follows in a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_y_valid | input | 1 | Word offered by the upper neighbour |
| in_y_word | input | WW | Word from the upper neighbour |
| in_x_valid | input | 1 | Word offered by the left neighbour |
| in_x_word | input | WW | Word from the left neighbour |
| busy_y_o | output | 1 | y slot occupied (to upper neighbour) |
| busy_x_o | output | 1 | x slot occupied (to left neighbour) |
| out_y_valid | output | 1 | Word offered to the lower neighbour |
| out_y_word | output | WW | Word to the lower neighbour, dy reduced |
| busy_y_dn | input | 1 | Lower neighbour's y slot occupied |
| out_x_valid | output | 1 | Word offered to the right neighbour |
| out_x_word | output | WW | Word to the right neighbour, dx reduced |
| busy_x_dn | input | 1 | Right neighbour's x slot occupied |
| op_req | input | 1 | Cell computation wants to start |
| op_go | output | 1 | Computation may start this cycle |
| cfg_we | output | 1 | Local configuration write pulse |
| cfg_waddr | output | AW | Address of that write |
| cfg_wdata | output | DW | Data of that write |
| rd_addr | input | AW | Configuration memory read address |
| rd_data | output | DW | Registered configuration memory read data |

## Verification
The hardest situations to reach from the array's edge are these: a word held by two busy neighbours that are then released together, a word with dx=0 waiting on a busy y neighbour while the x side is free, and two slots competing for the same output. Inside an array, these depend on traffic that cannot be steered. The bench therefore also drives one standalone cell with its own downstream busy lines, so each of these states can be set up and released on a chosen cycle. A 3x3 array fed at one corner then checks delivery against a scoreboard, and checks that the final contents do not depend on the injection order.

// File: rtl/cfg_mesh_pkg.sv
package cfg_mesh_pkg;

  typedef enum logic [1:0] {
    HOP_NONE = 2'd0,
    HOP_Y    = 2'd1,
    HOP_X    = 2'd2,
    HOP_HOME = 2'd3
  } hop_e;

  // Routing decision for one held word, given which exits are still free.
  function automatic hop_e pick_hop(
    input logic full,
    input logic dy_nz,
    input logic dx_nz,
    input logic y_free,
    input logic x_free,
    input logic home_free
  );
    hop_e h;
    h = HOP_NONE;
    if (full) begin
      if (dy_nz && dx_nz) begin
        if (y_free)      h = HOP_Y;
        else if (x_free) h = HOP_X;
      end else if (dy_nz) begin
        if (y_free) h = HOP_Y;
      end else if (dx_nz) begin
        if (x_free) h = HOP_X;
      end else begin
        if (home_free) h = HOP_HOME;
      end
    end
    return h;
  endfunction

endpackage

// File: rtl/cfg_slot.sv
module cfg_slot #(
  parameter int WW       = 18,
  parameter int FLAG_BIT = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [WW-1:0] in_word,
  input  logic          pop,
  output logic          full,
  output logic [WW-1:0] word
);
  logic load;

  assign load = in_valid && in_word[FLAG_BIT] && !full;

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
    end else if (load) begin
      full <= 1'b1;
    end else if (pop) begin
      full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) word <= in_word;
  end
endmodule

// File: rtl/cfg_hop_arb.sv
module cfg_hop_arb
  import cfg_mesh_pkg::*;
#(
  parameter int NSLOT = 2
) (
  input  logic [NSLOT-1:0] full,
  input  logic [NSLOT-1:0] dy_nz,
  input  logic [NSLOT-1:0] dx_nz,
  input  logic             busy_y_dn,
  input  logic             busy_x_dn,
  output hop_e             hop [NSLOT]
);
  // Lower slot index is served first; each exit is given out once per cycle.
  always_comb begin
    logic yf, xf, hf;
    yf = !busy_y_dn;
    xf = !busy_x_dn;
    hf = 1'b1;
    for (int i = 0; i < NSLOT; i++) begin
      hop[i] = pick_hop(full[i], dy_nz[i], dx_nz[i], yf, xf, hf);
      if (hop[i] == HOP_Y)    yf = 1'b0;
      if (hop[i] == HOP_X)    xf = 1'b0;
      if (hop[i] == HOP_HOME) hf = 1'b0;
    end
  end
endmodule

// File: rtl/cfg_store.sv
module cfg_store #(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cfg_mesh_cell.sv
module cfg_mesh_cell
  import cfg_mesh_pkg::*;
#(
  parameter int XW = 3,
  parameter int YW = 3,
  parameter int AW = 3,
  parameter int DW = 8,
  localparam int WW = 1 + YW + XW + AW + DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_y_valid,
  input  logic [WW-1:0] in_y_word,
  input  logic          in_x_valid,
  input  logic [WW-1:0] in_x_word,
  output logic          busy_y_o,
  output logic          busy_x_o,
  output logic          out_y_valid,
  output logic [WW-1:0] out_y_word,
  input  logic          busy_y_dn,
  output logic          out_x_valid,
  output logic [WW-1:0] out_x_word,
  input  logic          busy_x_dn,
  input  logic          op_req,
  output logic          op_go,
  output logic          cfg_we,
  output logic [AW-1:0] cfg_waddr,
  output logic [DW-1:0] cfg_wdata,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int NSLOT    = 2;
  localparam int ADDR_LSB = DW;
  localparam int DX_LSB   = DW + AW;
  localparam int DY_LSB   = DX_LSB + XW;
  localparam int FLAG_BIT = DY_LSB + YW;
  localparam logic [WW-1:0] DY_ONE = WW'(1) << DY_LSB;
  localparam logic [WW-1:0] DX_ONE = WW'(1) << DX_LSB;

  logic          s_in_v  [NSLOT];
  logic [WW-1:0] s_in_w  [NSLOT];
  logic [NSLOT-1:0] s_full, s_dy_nz, s_dx_nz, s_pop;
  logic [WW-1:0] s_word  [NSLOT];
  hop_e          s_hop   [NSLOT];

  assign s_in_v[0] = in_y_valid;
  assign s_in_w[0] = in_y_word;
  assign s_in_v[1] = in_x_valid;
  assign s_in_w[1] = in_x_word;

  // Slot 0 is fed from the y side, slot 1 from the x side.
  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    cfg_slot #(.WW(WW), .FLAG_BIT(FLAG_BIT)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .in_valid (s_in_v[i]),
      .in_word  (s_in_w[i]),
      .pop      (s_pop[i]),
      .full     (s_full[i]),
      .word     (s_word[i])
    );
    assign s_dy_nz[i] = |s_word[i][DY_LSB +: YW];
    assign s_dx_nz[i] = |s_word[i][DX_LSB +: XW];
    assign s_pop[i]   = (s_hop[i] != HOP_NONE);
  end

  cfg_hop_arb #(.NSLOT(NSLOT)) u_arb (
    .full      (s_full),
    .dy_nz     (s_dy_nz),
    .dx_nz     (s_dx_nz),
    .busy_y_dn (busy_y_dn),
    .busy_x_dn (busy_x_dn),
    .hop       (s_hop)
  );

  // Exit multiplexing: the arbiter grants each exit to at most one slot.
  logic          y_sel, x_sel, h_sel, h_any;
  logic [WW-1:0] h_word;

  always_comb begin
    y_sel = (s_hop[0] != HOP_Y);
    x_sel = (s_hop[0] != HOP_X);
    h_sel = (s_hop[0] != HOP_HOME);
  end

  assign out_y_valid = (s_hop[0] == HOP_Y) || (s_hop[1] == HOP_Y);
  assign out_x_valid = (s_hop[0] == HOP_X) || (s_hop[1] == HOP_X);
  assign h_any       = (s_hop[0] == HOP_HOME) || (s_hop[1] == HOP_HOME);
  assign out_y_word  = s_word[y_sel] - DY_ONE;
  assign out_x_word  = s_word[x_sel] - DX_ONE;
  assign h_word      = s_word[h_sel];

  assign busy_y_o = s_full[0];
  assign busy_x_o = s_full[1];

  cfg_store #(.AW(AW), .DW(DW)) u_store (
    .clk   (clk),
    .we    (h_any),
    .waddr (h_word[ADDR_LSB +: AW]),
    .wdata (h_word[DW-1:0]),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  logic cfg_arriving;
  assign cfg_arriving = (in_y_valid && in_y_word[FLAG_BIT]) ||
                        (in_x_valid && in_x_word[FLAG_BIT]);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_we <= 1'b0;
      op_go  <= 1'b0;
    end else begin
      cfg_we <= h_any;
      op_go  <= op_req && !(|s_full) && !cfg_arriving;
    end
  end

  always_ff @(posedge clk) begin
    if (h_any) begin
      cfg_waddr <= h_word[ADDR_LSB +: AW];
      cfg_wdata <= h_word[DW-1:0];
    end
  end
endmodule

// File: rtl/cfg_mesh_cell_chk.sv
module cfg_mesh_cell_chk #(
  parameter int XW = 3,
  parameter int YW = 3,
  parameter int AW = 3,
  parameter int DW = 8,
  localparam int WW = 1 + YW + XW + AW + DW,
  localparam int FLAG_BIT = WW - 1
) (
  input logic          clk,
  input logic          rst,
  input logic          in_y_valid,
  input logic [WW-1:0] in_y_word,
  input logic          busy_y_o,
  input logic          busy_x_o,
  input logic          out_y_valid,
  input logic [WW-1:0] out_y_word,
  input logic          busy_y_dn,
  input logic          out_x_valid,
  input logic [WW-1:0] out_x_word,
  input logic          busy_x_dn,
  input logic          op_req,
  input logic          op_go,
  input logic          cfg_we
);
  assert_no_push_busy_y_R10: assert property (@(posedge clk) disable iff (rst)
    out_y_valid |-> !busy_y_dn);

  assert_no_push_busy_x_R10: assert property (@(posedge clk) disable iff (rst)
    out_x_valid |-> !busy_x_dn);

  assert_data_word_ignored_R1: assert property (@(posedge clk) disable iff (rst)
    (in_y_valid && !in_y_word[FLAG_BIT] && !busy_y_o) |=> !busy_y_o);

  assert_forward_is_config_R2: assert property (@(posedge clk) disable iff (rst)
    out_y_valid |-> out_y_word[FLAG_BIT]);

  assert_forward_is_config_R3: assert property (@(posedge clk) disable iff (rst)
    out_x_valid |-> out_x_word[FLAG_BIT]);

  assert_write_from_held_R7: assert property (@(posedge clk) disable iff (rst)
    cfg_we |-> $past(busy_y_o || busy_x_o));

  assert_op_yields_R8: assert property (@(posedge clk) disable iff (rst)
    op_go |-> ($past(op_req) && !$past(busy_y_o || busy_x_o)));
endmodule

bind cfg_mesh_cell cfg_mesh_cell_chk #(.XW(XW), .YW(YW), .AW(AW), .DW(DW)) u_chk (.*);

// File: tb/cfg_mesh_cell_bench.sv
module cfg_mesh_cell_bench;
  localparam int XW = 3, YW = 3, AW = 3, DW = 8;
  localparam int WW = 1 + YW + XW + AW + DW;
  localparam int NR = 3, NC = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  function automatic logic [WW-1:0] mk(input logic f, input int dy, input int dx,
                                       input int a, input int d);
    return {f, YW'(dy), XW'(dx), AW'(a), DW'(d)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // ---------------- standalone cell ----------------
  logic          s_iyv = 0, s_ixv = 0, s_byd = 0, s_bxd = 0, s_opreq = 0;
  logic [WW-1:0] s_iyw = '0, s_ixw = '0;
  logic [AW-1:0] s_ra = '0;
  logic          s_by, s_bx, s_oyv, s_oxv, s_go, s_we;
  logic [WW-1:0] s_oyw, s_oxw;
  logic [AW-1:0] s_wa;
  logic [DW-1:0] s_wd, s_rd;

  cfg_mesh_cell #(.XW(XW), .YW(YW), .AW(AW), .DW(DW)) u_cfg_mesh_cell (
    .clk(clk), .rst(rst),
    .in_y_valid(s_iyv), .in_y_word(s_iyw), .in_x_valid(s_ixv), .in_x_word(s_ixw),
    .busy_y_o(s_by), .busy_x_o(s_bx),
    .out_y_valid(s_oyv), .out_y_word(s_oyw), .busy_y_dn(s_byd),
    .out_x_valid(s_oxv), .out_x_word(s_oxw), .busy_x_dn(s_bxd),
    .op_req(s_opreq), .op_go(s_go),
    .cfg_we(s_we), .cfg_waddr(s_wa), .cfg_wdata(s_wd),
    .rd_addr(s_ra), .rd_data(s_rd)
  );

  // ---------------- 3x3 array ----------------
  logic          drv_v = 0;
  logic [WW-1:0] drv_w = '0;
  logic [AW-1:0] arr_ra = '0;
  logic          iyv [NR][NC], ixv [NR][NC], oyv [NR][NC], oxv [NR][NC];
  logic [WW-1:0] iyw [NR][NC], ixw [NR][NC], oyw [NR][NC], oxw [NR][NC];
  logic          by [NR][NC], bx [NR][NC], byd [NR][NC], bxd [NR][NC];
  logic          awe [NR][NC], ago [NR][NC];
  logic [AW-1:0] awa [NR][NC];
  logic [DW-1:0] awd [NR][NC], ard [NR][NC];

  for (genvar r = 0; r < NR; r++) begin : g_r
    for (genvar c = 0; c < NC; c++) begin : g_c
      if (r == 0 && c == 0) begin : g_feed
        assign iyv[r][c] = drv_v;
        assign iyw[r][c] = drv_w;
      end else if (r == 0) begin : g_top
        assign iyv[r][c] = 1'b0;
        assign iyw[r][c] = '0;
      end else begin : g_ylink
        assign iyv[r][c] = oyv[r-1][c];
        assign iyw[r][c] = oyw[r-1][c];
      end
      if (c == 0) begin : g_left
        assign ixv[r][c] = 1'b0;
        assign ixw[r][c] = '0;
      end else begin : g_xlink
        assign ixv[r][c] = oxv[r][c-1];
        assign ixw[r][c] = oxw[r][c-1];
      end
      if (r == NR-1) begin : g_bot
        assign byd[r][c] = 1'b1;
      end else begin : g_ybusy
        assign byd[r][c] = by[r+1][c];
      end
      if (c == NC-1) begin : g_right
        assign bxd[r][c] = 1'b1;
      end else begin : g_xbusy
        assign bxd[r][c] = bx[r][c+1];
      end
      cfg_mesh_cell #(.XW(XW), .YW(YW), .AW(AW), .DW(DW)) u_cell (
        .clk(clk), .rst(rst),
        .in_y_valid(iyv[r][c]), .in_y_word(iyw[r][c]),
        .in_x_valid(ixv[r][c]), .in_x_word(ixw[r][c]),
        .busy_y_o(by[r][c]), .busy_x_o(bx[r][c]),
        .out_y_valid(oyv[r][c]), .out_y_word(oyw[r][c]), .busy_y_dn(byd[r][c]),
        .out_x_valid(oxv[r][c]), .out_x_word(oxw[r][c]), .busy_x_dn(bxd[r][c]),
        .op_req(1'b0), .op_go(ago[r][c]),
        .cfg_we(awe[r][c]), .cfg_waddr(awa[r][c]), .cfg_wdata(awd[r][c]),
        .rd_addr(arr_ra), .rd_data(ard[r][c])
      );
    end
  end

  // ---------------- scoreboard ----------------
  logic [31:0] exp_q [$];
  bit sb_on = 1'b0;

  function automatic logic [31:0] sb_key(input int r, input int c, input int a, input int d);
    return {r[7:0], c[7:0], a[7:0], d[7:0]};
  endfunction

  function automatic int exp_d(input int r, input int c, input int a);
    return ((r * 16 + c * 4 + a) ^ 'h5A) & 'hFF;
  endfunction

  always @(negedge clk) begin
    if (sb_on) begin
      for (int r = 0; r < NR; r++) begin
        for (int c = 0; c < NC; c++) begin
          if (awe[r][c]) begin
            logic [31:0] k;
            int hit;
            k = sb_key(r, c, int'(awa[r][c]), int'(awd[r][c]));
            hit = -1;
            for (int i = 0; i < exp_q.size(); i++) if (exp_q[i] == k && hit < 0) hit = i;
            n_chk++;
            if (hit < 0) begin
              n_fail++;
              $display("FAIL R7 unexpected write actual=%0h expected=queued", k);
            end else begin
              exp_q.delete(hit);
            end
          end
        end
      end
    end
  end

  // driver: inject at corner cell, push expectation
  task automatic arr_send(input int r, input int c, input int a, input int d);
    while (by[0][0]) @(negedge clk);
    exp_q.push_back(sb_key(r, c, a, d));
    drv_v = 1'b1;
    drv_w = mk(1'b1, r, c, a, d);
    @(negedge clk);
    drv_v = 1'b0;
  endtask

  task automatic arr_drain();
    for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
    chk("R11 scoreboard drained", exp_q.size(), 0);
  endtask

  task automatic put_y(input logic [WW-1:0] w);
    s_iyv = 1'b1; s_iyw = w;
    @(negedge clk);
    s_iyv = 1'b0;
  endtask

  task automatic put_x(input logic [WW-1:0] w);
    s_ixv = 1'b1; s_ixw = w;
    @(negedge clk);
    s_ixv = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 reset busy_y", s_by, 0);
    chk("R10 reset busy_x", s_bx, 0);
    chk("R10 reset out_y", s_oyv, 0);
    chk("R10 reset out_x", s_oxv, 0);
    chk("R8 reset op_go", s_go, 0);
    chk("R7 reset cfg_we", s_we, 0);

    // R2: both nonzero, y free
    s_byd = 0; s_bxd = 0;
    put_y(mk(1, 3, 2, 1, 'hA1));
    chk("R2 out_y valid", s_oyv, 1);
    chk("R2 out_x idle", s_oxv, 0);
    chk("R2 y word", s_oyw, mk(1, 2, 2, 1, 'hA1));
    @(negedge clk);
    chk("R10 slot freed after hop", s_by, 0);

    // R3: y busy, x free
    s_byd = 1; s_bxd = 0;
    put_y(mk(1, 3, 2, 2, 'hB2));
    chk("R3 out_x valid", s_oxv, 1);
    chk("R3 out_y idle", s_oyv, 0);
    chk("R3 x word", s_oxw, mk(1, 3, 1, 2, 'hB2));
    @(negedge clk);

    // R4 hold, then R9 simultaneous release
    s_byd = 1; s_bxd = 1;
    put_y(mk(1, 1, 1, 3, 'hC3));
    chk("R4 no y", s_oyv, 0);
    chk("R4 no x", s_oxv, 0);
    chk("R4 busy held", s_by, 1);
    @(negedge clk);
    chk("R4 still held", s_by, 1);
    s_byd = 0; s_bxd = 0;
    #1;
    chk("R9 y wins", s_oyv, 1);
    chk("R9 x not used", s_oxv, 0);
    chk("R9 y word", s_oyw, mk(1, 0, 1, 3, 'hC3));
    @(negedge clk);

    // R5: dx=0 never goes x
    s_byd = 1; s_bxd = 0;
    put_y(mk(1, 2, 0, 4, 'hD4));
    chk("R5 no x with dx=0", s_oxv, 0);
    chk("R5 waits", s_oyv, 0);
    @(negedge clk);
    chk("R5 still held", s_by, 1);
    s_byd = 0;
    #1;
    chk("R5 y word", s_oyw, mk(1, 1, 0, 4, 'hD4));
    chk("R5 y valid", s_oyv, 1);
    @(negedge clk);

    // R6: dy=0 goes x only
    s_byd = 0; s_bxd = 0;
    put_y(mk(1, 0, 3, 5, 'hE5));
    chk("R6 x valid", s_oxv, 1);
    chk("R6 y idle", s_oyv, 0);
    chk("R6 x word", s_oxw, mk(1, 0, 2, 5, 'hE5));
    @(negedge clk);

    // R7: local write via y slot and x slot
    put_y(mk(1, 0, 0, 6, 'hC3));
    @(negedge clk);
    chk("R7 we", s_we, 1);
    chk("R7 waddr", s_wa, 6);
    chk("R7 wdata", s_wd, 'hC3);
    s_ra = 6;
    @(negedge clk);
    chk("R7 we one cycle", s_we, 0);
    chk("R7 readback", s_rd, 'hC3);
    put_x(mk(1, 0, 0, 2, 'h3C));
    @(negedge clk);
    chk("R7 we x slot", s_we, 1);
    s_ra = 2;
    @(negedge clk);
    chk("R7 readback x slot", s_rd, 'h3C);

    // R1: flag=0 ignored
    s_ra = 6;
    put_y(mk(0, 0, 0, 6, 'h11));
    chk("R1 busy stays low", s_by, 0);
    @(negedge clk);
    chk("R1 no write", s_we, 0);
    chk("R1 memory unchanged", s_rd, 'hC3);

    // R8: op_go yields to routing
    s_byd = 1; s_bxd = 1; s_opreq = 1;
    put_y(mk(1, 1, 1, 0, 'h77));
    chk("R8 go low on arrival", s_go, 0);
    @(negedge clk);
    chk("R8 go low while held", s_go, 0);
    s_byd = 0; s_bxd = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R8 go after idle", s_go, 1);
    s_opreq = 0;

    // R12: both slots want y
    s_byd = 1; s_bxd = 1;
    s_ixv = 1'b1; s_ixw = mk(1, 2, 0, 1, 'h22);
    put_y(mk(1, 1, 0, 1, 'h11));
    s_ixv = 1'b0;
    chk("R12 both held y", s_by, 1);
    chk("R12 both held x", s_bx, 1);
    s_byd = 0;
    #1;
    chk("R12 y slot first", s_oyw, mk(1, 0, 0, 1, 'h11));
    @(negedge clk);
    chk("R12 x slot waits", s_bx, 1);
    chk("R12 x slot second", s_oyw, mk(1, 1, 0, 1, 'h22));
    @(negedge clk);
    chk("R12 x slot gone", s_bx, 0);

    // R11: array, forward order then clobber then reverse order
    sb_on = 1'b1;
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++)
        for (int k = 0; k < 2; k++) arr_send(r, c, 1 + 4 * k, exp_d(r, c, 1 + 4 * k));
    arr_drain();
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++)
        for (int k = 0; k < 2; k++) arr_send(r, c, 1 + 4 * k, 0);
    arr_drain();
    for (int r = NR - 1; r >= 0; r--)
      for (int c = NC - 1; c >= 0; c--)
        for (int k = 1; k >= 0; k--) arr_send(r, c, 1 + 4 * k, exp_d(r, c, 1 + 4 * k));
    arr_drain();
    for (int k = 0; k < 2; k++) begin
      arr_ra = AW'(1 + 4 * k);
      @(negedge clk);
      for (int r = 0; r < NR; r++)
        for (int c = 0; c < NC; c++)
          chk("R11 final contents", ard[r][c], exp_d(r, c, 1 + 4 * k));
    end
    finish_run();
  end
endmodule